// File: doc/BRIEF.md
# Down-Counting Timer Peripheral

A memory-mapped timer with a parameterized number of independent channels (two by default), each holding a counter that only ever counts down. A channel starts a countdown from a value written by software into its preset register. It either stops at zero or reloads the preset and keeps running. Elapsed time on a free-running channel is the bitwise inverse of its live count. When a countdown expires, a sticky flag is raised. The flag, gated by an enable bit, drives that channel's interrupt output.

Software reaches every writable register through three addresses. One replaces the whole word, one ORs in the written ones and one clears them, so single bits change without a read-modify-write. Each channel picks its count pulse from a select field. The choices are every clock, a slow reference strobe brought in on its own pin, or nothing. A global control word carries a soft-reset trigger, and a read-only word reports the major version.

Top module: `dtmr_top`

## Requirements
- R1: After reset, every channel control, live count and preset word reads zero and no interrupt is asserted. Channel n has its control word at 0x20+n*0x40, its live count at 0x30+n*0x40 and its preset at 0x40+n*0x40. Unmapped addresses read zero.
- R2: A write at a register's base address replaces it, a write at base+0x4 sets the written one-bits, and a write at base+0x8 clears them. Bits written as zero through either alias keep their value.
- R3: Control bits 3:0 select the count pulse. 0xF counts on every clock, 0xB counts on a clock where `ref_strobe` is high, and any other code never counts, whatever the strobe does.
- R4: Each count pulse lowers a nonzero live count by exactly one.
- R5: With control bit 6 (auto-reload) clear, a channel at zero stays at zero on further pulses.
- R6: With bit 6 set, a pulse at zero loads the preset, so a preset P gives one expiry every P+1 pulses.
- R7: With control bit 7 (immediate load) set, a preset write also places the written value in the live count at the same clock edge. With bit 7 clear, a preset write leaves the live count alone.
- R8: Control bit 15 is a sticky flag. A pulse that takes the live count from 1 to 0 sets it, and it stays set until software clears it. An expiry on the same edge as a clear wins.
- R9: Interrupt output n is the flag of channel n ANDed with its control bit 14. Clearing bit 14 masks the output but keeps the flag.
- R10: Writing 0x8000 to the control clear alias (base+0x8) drops the flag and the interrupt.
- R11: Address 0x120 reads 0x02000000 (major version 2 in bits 31:24) and ignores writes.
- R12: A write at 0x00 or 0x04 with bit 31 set returns every channel's control, live count and preset to zero on that edge. The global word always reads zero.
- R13: Writes to a live count address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ref_strobe | input | 1 | One-clock reference pulse, already in the clk domain |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (9) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH (2) | Per-channel interrupt, flag AND enable |

## Verification
A corrupted live count reaches the read port right away, and a miscounted decrement or reload becomes visible at the next pulse. The bench therefore reads the count after a known number of edges rather than waiting for an interrupt. A lost or stuck flag appears at the irq pin within the same cycle, because the output is a plain gate of two register bits. A wrong alias decode shows in the readback on the very next read. The set-wins-over-clear case needs the clear write to land exactly on the expiring edge, so the bench times that write by counting edges from a known count.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } reg_op_e;

  // Address layout (byte offsets)
  localparam int OFS_GLOBAL  = 'h000;
  localparam int OFS_CTL     = 'h020;
  localparam int OFS_CNT     = 'h030;
  localparam int OFS_PRE     = 'h040;
  localparam int CH_STRIDE   = 'h040;
  localparam int OFS_VERSION = 'h120;
  localparam int ALIAS_SET   = 'h4;
  localparam int ALIAS_CLR   = 'h8;

  // Control word bit positions
  localparam int B_RELOAD = 6;
  localparam int B_UPDATE = 7;
  localparam int B_IEN    = 14;
  localparam int B_FLAG   = 15;
  localparam int B_SRST   = 31;
  localparam int VER_LSB  = 24;

  // Pulse source codes
  localparam logic [3:0] SRC_EVERY = 4'hF;
  localparam logic [3:0] SRC_REF   = 4'hB;

  function automatic reg_op_e decode_op(input int addr, input int base, input logic wr);
    reg_op_e op;
    op = OP_NONE;
    if (wr) begin
      if (addr == base)                  op = OP_WRITE;
      else if (addr == base + ALIAS_SET) op = OP_SET;
      else if (addr == base + ALIAS_CLR) op = OP_CLEAR;
    end
    return op;
  endfunction

  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] data,
                                                   input reg_op_e op);
    logic [DATA_W-1:0] res;
    case (op)
      OP_WRITE: res = data;
      OP_SET:   res = cur | data;
      OP_CLEAR: res = cur & ~data;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/dtmr_tick_sel.sv
module dtmr_tick_sel
  import dtmr_pkg::*;
(
  input  logic [3:0] src_sel,
  input  logic       ref_strobe,
  output logic       tick
);

  always_comb begin
    case (src_sel)
      SRC_EVERY: tick = 1'b1;
      SRC_REF:   tick = ref_strobe;
      default:   tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              ref_strobe,
  input  reg_op_e           ctl_op,
  input  reg_op_e           pre_op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_word,
  output logic [CNT_W-1:0]  cnt_word,
  output logic [CNT_W-1:0]  pre_word,
  output logic              irq
);

  localparam int DW = DATA_W;

  logic [3:0]       sel_q, sel_d;
  logic             rld_q, rld_d;
  logic             upd_q, upd_d;
  logic             ien_q, ien_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pre_q, pre_d;

  logic             tick;
  logic             ctl_wr, pre_wr;
  logic [DW-1:0]    ctl_new, pre_new;
  logic             load_now, expire, at_zero;
  logic             ctl_en, pre_en, cnt_en;

  dtmr_tick_sel u_tick_sel (
    .src_sel    (sel_q),
    .ref_strobe (ref_strobe),
    .tick       (tick)
  );

  // Next-state logic
  always_comb begin
    ctl_word           = '0;
    ctl_word[3:0]      = sel_q;
    ctl_word[B_RELOAD] = rld_q;
    ctl_word[B_UPDATE] = upd_q;
    ctl_word[B_IEN]    = ien_q;
    ctl_word[B_FLAG]   = flag_q;

    ctl_wr  = (ctl_op != OP_NONE);
    pre_wr  = (pre_op != OP_NONE);
    ctl_new = merge_word(ctl_word, wdata, ctl_op);
    pre_new = merge_word(DW'(pre_q), wdata, pre_op);

    load_now = pre_wr && upd_q;
    at_zero  = (cnt_q == '0);
    expire   = tick && !load_now && (cnt_q == CNT_W'(1));

    sel_d  = ctl_wr ? ctl_new[3:0]     : sel_q;
    rld_d  = ctl_wr ? ctl_new[B_RELOAD] : rld_q;
    upd_d  = ctl_wr ? ctl_new[B_UPDATE] : upd_q;
    ien_d  = ctl_wr ? ctl_new[B_IEN]    : ien_q;
    flag_d = (ctl_wr ? ctl_new[B_FLAG] : flag_q) | expire;

    pre_d = pre_wr ? pre_new[CNT_W-1:0] : pre_q;

    if (load_now)      cnt_d = pre_new[CNT_W-1:0];
    else if (!tick)    cnt_d = cnt_q;
    else if (!at_zero) cnt_d = cnt_q - CNT_W'(1);
    else if (rld_q)    cnt_d = pre_q;
    else               cnt_d = '0;

    if (srst) begin
      sel_d  = '0;
      rld_d  = 1'b0;
      upd_d  = 1'b0;
      ien_d  = 1'b0;
      flag_d = 1'b0;
      pre_d  = '0;
      cnt_d  = '0;
    end

    ctl_en = srst | ctl_wr | expire;
    pre_en = srst | pre_wr;
    cnt_en = srst | load_now | tick;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rld_q  <= 1'b0;
      upd_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctl_en) begin
        sel_q  <= sel_d;
        rld_q  <= rld_d;
        upd_q  <= upd_d;
        ien_q  <= ien_d;
        flag_q <= flag_d;
      end
      if (pre_en) pre_q <= pre_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_word = cnt_q;
  assign pre_word = pre_q;
  assign irq      = flag_q & ien_q;

  // Assertions
  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_zero && !srst && !load_now) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !rld_q && !srst && !pre_wr) |=> (cnt_q == '0));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && rld_q && !srst && !load_now) |=> (cnt_q == $past(pre_q)));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !srst && !ctl_wr) |=> flag_q);

  assert_flag_on_expire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q == CNT_W'(1)) && !srst && !load_now) |=> flag_q);

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cnt_q == '0 && pre_q == '0 && !flag_q && !ien_q));

endmodule

// File: rtl/dtmr_bus_decode.sv
module dtmr_bus_decode
  import dtmr_pkg::*;
#(
  parameter int       NUM_CH        = 2,
  parameter int       CNT_W         = 32,
  parameter int       ADDR_W        = 9,
  parameter int       VERSION_MAJOR = 2
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] ctl_words [NUM_CH],
  input  logic [CNT_W-1:0]  cnt_words [NUM_CH],
  input  logic [CNT_W-1:0]  pre_words [NUM_CH],
  output reg_op_e           ctl_op    [NUM_CH],
  output reg_op_e           pre_op    [NUM_CH],
  output logic              srst,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int DW = DATA_W;
  localparam logic [DW-1:0] VERSION_WORD = DW'(VERSION_MAJOR) << VER_LSB;

  int      a;
  reg_op_e glob_op;

  assign a = int'(bus_addr);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch_dec
    assign ctl_op[n] = decode_op(a, OFS_CTL + n * CH_STRIDE, bus_wr);
    assign pre_op[n] = decode_op(a, OFS_PRE + n * CH_STRIDE, bus_wr);
  end

  assign glob_op = decode_op(a, OFS_GLOBAL, bus_wr);
  assign srst    = bus_wdata[B_SRST] && (glob_op == OP_WRITE || glob_op == OP_SET);

  always_comb begin
    bus_rdata = '0;
    if (a == OFS_VERSION) bus_rdata = VERSION_WORD;
    for (int n = 0; n < NUM_CH; n++) begin
      if (a == OFS_CTL + n * CH_STRIDE) bus_rdata = ctl_words[n];
      if (a == OFS_CNT + n * CH_STRIDE) bus_rdata = DW'(cnt_words[n]);
      if (a == OFS_PRE + n * CH_STRIDE) bus_rdata = DW'(pre_words[n]);
    end
  end

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter int NUM_CH        = 2,
  parameter int CNT_W         = 32,
  parameter int ADDR_W        = 9,
  parameter int VERSION_MAJOR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_strobe,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  logic [DATA_W-1:0] ctl_words [NUM_CH];
  logic [CNT_W-1:0]  cnt_words [NUM_CH];
  logic [CNT_W-1:0]  pre_words [NUM_CH];
  reg_op_e           ctl_op    [NUM_CH];
  reg_op_e           pre_op    [NUM_CH];
  logic              srst;

  dtmr_bus_decode #(
    .NUM_CH        (NUM_CH),
    .CNT_W         (CNT_W),
    .ADDR_W        (ADDR_W),
    .VERSION_MAJOR (VERSION_MAJOR)
  ) u_decode (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctl_words (ctl_words),
    .cnt_words (cnt_words),
    .pre_words (pre_words),
    .ctl_op    (ctl_op),
    .pre_op    (pre_op),
    .srst      (srst),
    .bus_rdata (bus_rdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dtmr_channel #(
      .CNT_W (CNT_W)
    ) u_channel (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst       (srst),
      .ref_strobe (ref_strobe),
      .ctl_op     (ctl_op[n]),
      .pre_op     (pre_op[n]),
      .wdata      (bus_wdata),
      .ctl_word   (ctl_words[n]),
      .cnt_word   (cnt_words[n]),
      .pre_word   (pre_words[n]),
      .irq        (irq[n])
    );
  end

endmodule

// File: tb/dtmr_top_tb.sv
module dtmr_top_tb;

  localparam int A_GLB  = 'h000;
  localparam int A_CTL0 = 'h020;
  localparam int A_CNT0 = 'h030;
  localparam int A_PRE0 = 'h040;
  localparam int A_CTL1 = 'h060;
  localparam int A_CNT1 = 'h070;
  localparam int A_PRE1 = 'h080;
  localparam int A_VER  = 'h120;

  logic        clk;
  logic        rst_n;
  logic        ref_strobe;
  logic        bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int total;
  int bad;
  bit done;

  dtmr_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_strobe (ref_strobe),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Called at a negedge or just after: one write edge, returns at the next negedge
  task automatic wr(input int addr, input logic [31:0] data);
    bus_addr  = addr[8:0];
    bus_wdata = data;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    bus_addr = addr[8:0];
    #1;
    data = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input string what, input int addr, input logic [31:0] exp);
    logic [31:0] v;
    rd(addr, v);
    chk(req, what, v, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe_once;
    ref_strobe = 1'b1;
    @(negedge clk);
    ref_strobe = 1'b0;
  endtask

  task automatic test_reset;
    rd_chk("R1", "ctl0 reset",   A_CTL0, 32'h0);
    rd_chk("R1", "count0 reset", A_CNT0, 32'h0);
    rd_chk("R1", "preset0 reset",A_PRE0, 32'h0);
    rd_chk("R1", "ctl1 reset",   A_CTL1, 32'h0);
    rd_chk("R1", "count1 reset", A_CNT1, 32'h0);
    rd_chk("R1", "preset1 reset",A_PRE1, 32'h0);
    rd_chk("R1", "unmapped",     'h0F0,  32'h0);
    chk("R1", "irq reset", {30'h0, irq}, 32'h0);
  endtask

  task automatic test_version;
    rd_chk("R11", "version", A_VER, 32'h0200_0000);
    wr(A_VER, 32'hFFFF_FFFF);
    rd_chk("R11", "version after write", A_VER, 32'h0200_0000);
  endtask

  task automatic test_alias;
    wr(A_CTL1, 32'h0000_4005);
    rd_chk("R2", "base write", A_CTL1, 32'h0000_4005);
    wr(A_CTL1 + 4, 32'h0000_0040);
    rd_chk("R2", "set alias", A_CTL1, 32'h0000_4045);
    wr(A_CTL1 + 8, 32'h0000_4000);
    rd_chk("R2", "clear alias", A_CTL1, 32'h0000_0045);
    wr(A_CTL1, 32'h0);
  endtask

  task automatic test_no_source;
    wr(A_CTL0, 32'h0000_0083);
    wr(A_PRE0, 32'd10);
    rd_chk("R7", "immediate load", A_CNT0, 32'd10);
    strobe_once();
    idle(3);
    rd_chk("R3", "code 3 never counts", A_CNT0, 32'd10);
  endtask

  task automatic test_oneshot;
    wr(A_PRE0, 32'd5);
    wr(A_CTL0, 32'h0000_408F);  // every clock, immediate load, irq enable
    rd_chk("R4", "no pulse on ctl write edge", A_CNT0, 32'd5);
    idle(2);
    rd_chk("R4", "two pulses", A_CNT0, 32'd3);
    chk("R9", "irq before expiry", {31'h0, irq[0]}, 32'h0);
    idle(3);
    rd_chk("R8", "expired count", A_CNT0, 32'd0);
    rd_chk("R8", "flag set", A_CTL0, 32'h0000_C08F);
    chk("R9", "irq on expiry", {31'h0, irq[0]}, 32'h1);
    idle(4);
    rd_chk("R5", "holds at zero", A_CNT0, 32'd0);
    rd_chk("R8", "flag sticky", A_CTL0, 32'h0000_C08F);
  endtask

  task automatic test_mask;
    wr(A_CTL0 + 8, 32'h0000_4000);
    chk("R9", "masked irq", {31'h0, irq[0]}, 32'h0);
    rd_chk("R9", "flag kept while masked", A_CTL0, 32'h0000_808F);
    wr(A_CTL0 + 4, 32'h0000_4000);
    chk("R9", "unmasked irq", {31'h0, irq[0]}, 32'h1);
    wr(A_CTL0 + 8, 32'h0000_8000);
    chk("R10", "irq after flag clear", {31'h0, irq[0]}, 32'h0);
    rd_chk("R10", "flag cleared", A_CTL0, 32'h0000_408F);
  endtask

  task automatic test_update_off;
    wr(A_CTL0 + 8, 32'h0000_0080);
    wr(A_PRE0, 32'd7);
    rd_chk("R7", "count kept without immediate load", A_CNT0, 32'd0);
    rd_chk("R7", "preset stored", A_PRE0, 32'd7);
  endtask

  task automatic test_reload;
    wr(A_CTL1, 32'h0000_0080);
    wr(A_PRE1, 32'd3);
    wr(A_CTL1, 32'h0000_004F);  // every clock, auto-reload
    rd_chk("R6", "start count", A_CNT1, 32'd3);
    idle(3);
    rd_chk("R6", "reached zero", A_CNT1, 32'd0);
    rd_chk("R8", "flag on first expiry", A_CTL1, 32'h0000_804F);
    chk("R9", "disabled irq stays low", {31'h0, irq[1]}, 32'h0);
    idle(1);
    rd_chk("R6", "reloaded", A_CNT1, 32'd3);
    wr(A_CTL1 + 8, 32'h0000_8000);
    rd_chk("R10", "flag cleared mid-run", A_CTL1, 32'h0000_004F);
    rd_chk("R6", "count after clear edge", A_CNT1, 32'd2);
    idle(2);
    rd_chk("R8", "flag on second expiry", A_CTL1, 32'h0000_804F);
    idle(3);
    rd_chk("R6", "count before collision", A_CNT1, 32'd1);
    wr(A_CTL1 + 8, 32'h0000_8000);  // clear on the expiring edge
    rd_chk("R8", "expiry wins over clear", A_CTL1, 32'h0000_804F);
  endtask

  task automatic test_ref;
    wr(A_CTL1, 32'h0000_008B);  // reference strobe, immediate load
    wr(A_PRE1, 32'd4);
    rd_chk("R7", "ref channel loaded", A_CNT1, 32'd4);
    strobe_once();
    idle(2);
    rd_chk("R3", "one strobe", A_CNT1, 32'd3);
    strobe_once();
    rd_chk("R3", "two strobes", A_CNT1, 32'd2);
  endtask

  task automatic test_count_ro;
    wr(A_CNT1, 32'h0000_1234);
    rd_chk("R13", "count write ignored", A_CNT1, 32'd2);
    rd_chk("R13", "preset untouched", A_PRE1, 32'd4);
  endtask

  task automatic test_soft_reset;
    wr(A_CTL0 + 4, 32'h0000_8000);
    chk("R12", "irq before soft reset", {31'h0, irq[0]}, 32'h1);
    wr(A_GLB + 4, 32'h8000_0000);
    rd_chk("R12", "ctl0",    A_CTL0, 32'h0);
    rd_chk("R12", "preset0", A_PRE0, 32'h0);
    rd_chk("R12", "ctl1",    A_CTL1, 32'h0);
    rd_chk("R12", "count1",  A_CNT1, 32'h0);
    rd_chk("R12", "preset1", A_PRE1, 32'h0);
    rd_chk("R12", "global reads zero", A_GLB, 32'h0);
    chk("R12", "irq after soft reset", {30'h0, irq}, 32'h0);
  endtask

  initial begin
    total      = 0;
    bad        = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    ref_strobe = 1'b0;
    bus_wr     = 1'b0;
    bus_addr   = '0;
    bus_wdata  = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    test_reset();
    test_version();
    test_alias();
    test_no_source();
    test_oneshot();
    test_mask();
    test_update_off();
    test_reload();
    test_ref();
    test_count_ro();
    test_soft_reset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule